// File: doc/BRIEF.md
# Per-Sector Detector Coincidence Lookup

This block applies one programmable three-input rule to each of six detector sectors. Each sector supplies three hit bits: two from calorimeter-type systems (an inner and an outer calorimeter layer) and one from a time-of-flight counter. The three bits form an index into an 8-bit truth-table word, and the selected bit becomes that sector's pass flag. All sectors share the same word, so one register write sets the rule for the whole detector. The six pass flags are registered and sent to a second-level decision unit.

Control software programs the truth table through a plain register port and can read the stored word back. Because the index bit order is fixed, the usual selections each map to a fixed word. The single-detector selections are time-of-flight 0xAA, outer calorimeter 0xCC and inner calorimeter 0xF0. The pairwise OR selections are 0xFC, 0xFA and 0xEE, and the OR of all three is 0xFE. The pairwise AND selections are 0xC0, 0xA0 and 0x88, and the AND of all three is 0x80.

Hit vectors enter through a valid/ready handshake, and pass vectors leave through another one. A transfer takes place on a clock edge where both valid and ready are high. The input side is ready whenever the output register is empty or is being drained in the same cycle. While the downstream side holds ready low, a presented result stays unchanged, and no new input is accepted.

Top module: `sector_coinc_lut`

## Requirements
- R1: After reset, the stored table word reads 0x00, out_valid is 0 and in_ready is 1.
- R2: For each sector s, the index is {ecc_hit[s], ecp_hit[s], stof_hit[s]}, with ecc_hit as the most significant bit. The pass flag is bit <index> of the table word.
- R3: All six sectors use the same table word, and each sector is evaluated only from its own three hit bits.
- R4: A vector accepted on a clock edge appears on out_pass with out_valid high right after that edge. If no new vector is accepted and out_ready is 1, out_valid is low after the next edge.
- R5: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_pass stays unchanged. in_ready equals (not out_valid) or out_ready.
- R6: A table write takes effect on the edge where cfg_we is sampled high. A vector accepted on that same edge is judged by the old word, and a vector accepted on any later edge is judged by the new word.
- R7: cfg_rdata returns the word last written. It does not change when cfg_we is low.
- R8: The single-detector words 0xAA, 0xCC and 0xF0 pass a sector exactly when its time-of-flight, outer-calorimeter or inner-calorimeter hit, respectively, is set.
- R9: The OR words pass a sector when any hit in the named set is set: 0xFC for inner or outer calorimeter, 0xFA for inner calorimeter or time-of-flight, 0xEE for outer calorimeter or time-of-flight, and 0xFE for any of the three.
- R10: The AND words pass a sector only when every hit in the named set is set: 0xC0 for inner and outer calorimeter, 0xA0 for inner calorimeter and time-of-flight, 0x88 for outer calorimeter and time-of-flight, and 0x80 for all three.
- R11: While the table word is 0x00, every accepted vector yields out_pass equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_wdata | input | 8 | Table word to write |
| cfg_rdata | output | 8 | Stored table word |
| in_valid | input | 1 | Hit vector valid |
| in_ready | output | 1 | Block can take a hit vector |
| ecc_hit | input | 6 | Inner calorimeter hit, one bit per sector |
| ecp_hit | input | 6 | Outer calorimeter hit, one bit per sector |
| stof_hit | input | 6 | Time-of-flight hit, one bit per sector |
| out_valid | output | 1 | Pass vector valid |
| out_ready | input | 1 | Downstream accepts the pass vector |
| out_pass | output | 6 | Per-sector pass flags |

## Verification
A corrupted table word is visible on cfg_rdata right after the edge that corrupted it. It also shows up on out_pass one edge after the first vector whose sector indices select a corrupted bit. Stepping all eight indices across the sectors for every standard word therefore exposes any bad bit, or any swapped index bit, within eight accepted vectors. A wrong output-register state shows up as a lost, repeated or changed result. The bench detects this at the first stalled or resumed handshake, by comparing every transfer in order against the results it expects.

// File: rtl/sclut_pkg.sv
package sclut_pkg;
  localparam int unsigned DET_COUNT = 3;
  localparam int unsigned IDX_W     = DET_COUNT;
  localparam int unsigned TBL_W     = 1 << IDX_W;
  typedef logic [TBL_W-1:0] tbl_word_t;
  typedef logic [IDX_W-1:0] tbl_idx_t;
endpackage

// File: rtl/sclut_cfg_reg.sv
module sclut_cfg_reg
  import sclut_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  tbl_word_t wdata,
  output tbl_word_t table_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  table_q <= '0;
    else if (we) table_q <= wdata;
  end

  assert_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> table_q == $past(wdata));
  assert_table_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(table_q));
endmodule

// File: rtl/sclut_sector_eval.sv
module sclut_sector_eval
  import sclut_pkg::*;
(
  input  tbl_word_t table_i,
  input  logic      ecc,
  input  logic      ecp,
  input  logic      stof,
  output logic      pass
);
  tbl_idx_t idx;
  always_comb begin
    idx  = {ecc, ecp, stof};
    pass = table_i[idx];
  end
endmodule

// File: rtl/sclut_out_stage.sv
module sclut_out_stage #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;
  always_comb begin
    in_ready = !out_valid || out_ready;
    take     = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  assert_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  assert_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);
endmodule

// File: rtl/sector_coinc_lut.sv
module sector_coinc_lut
  import sclut_pkg::*;
#(
  parameter int unsigned NUM_SECTORS = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [TBL_W-1:0]       cfg_wdata,
  output logic [TBL_W-1:0]       cfg_rdata,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NUM_SECTORS-1:0] ecc_hit,
  input  logic [NUM_SECTORS-1:0] ecp_hit,
  input  logic [NUM_SECTORS-1:0] stof_hit,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [NUM_SECTORS-1:0] out_pass
);
  tbl_word_t              table_q;
  logic [NUM_SECTORS-1:0] pass_comb;

  sclut_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .table_q(table_q)
  );

  assign cfg_rdata = table_q;

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sector
    sclut_sector_eval u_eval (
      .table_i(table_q),
      .ecc    (ecc_hit[s]),
      .ecp    (ecp_hit[s]),
      .stof   (stof_hit[s]),
      .pass   (pass_comb[s])
    );
  end

  sclut_out_stage #(.W(NUM_SECTORS)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (pass_comb),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_pass)
  );

  assert_empty_table_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && table_q == '0) |=> (out_pass == '0));
  assert_full_table_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && table_q == '1) |=> (out_pass == '1));
  assert_index_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && table_q == tbl_word_t'(8'hF0)) |=> (out_pass == $past(ecc_hit)));
endmodule

// File: tb/sector_coinc_lut_bench.sv
module sector_coinc_lut_bench;
  localparam int NS = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00, cfg_rdata;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [NS-1:0] ecc_hit = '0, ecp_hit = '0, stof_hit = '0, out_pass;

  always #2.5 clk = ~clk;

  sector_coinc_lut u_sector_coinc_lut (.*);

  int nvec = 0, nfail = 0;
  bit done = 1'b0, bp_mode = 1'b0;
  logic [7:0] tbl = 8'h00;
  logic [NS-1:0] exp_q[$];
  string tag_q[$];
  bit hold_prev = 1'b0;
  logic [NS-1:0] held;

  function automatic logic [NS-1:0] model(input logic [7:0] t, input logic [NS-1:0] a, b, c);
    logic [NS-1:0] r;
    for (int s = 0; s < NS; s++) r[s] = t[{a[s], b[s], c[s]}];
    return r;
  endfunction

  function automatic logic rule(input int op, input logic e, p, t);
    case (op)
      0: return t;
      1: return p;
      2: return e;
      3: return e | p;
      4: return e | t;
      5: return p | t;
      6: return e | p | t;
      7: return e & p;
      8: return e & t;
      9: return p & t;
      default: return e & p & t;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    out_ready = bp_mode ? 1'($urandom % 2) : 1'b1;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      hold_prev = 1'b0;
    end else begin
      if (hold_prev)
        check(out_valid && out_pass == held, "R5", {1'b0, out_valid, out_pass}, {2'b01, held});
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", {2'b0, out_pass}, 8'hxx);
        end else begin
          logic [NS-1:0] e;
          string tg;
          e = exp_q.pop_front();
          tg = tag_q.pop_front();
          check(out_pass == e, tg, {2'b0, out_pass}, {2'b0, e});
        end
      end
      hold_prev = out_valid && !out_ready;
      held = out_pass;
    end
  end

  task automatic send(input logic [NS-1:0] a, b, c, input logic [NS-1:0] e, input string tag);
    @(posedge clk); #1;
    in_valid = 1'b1; ecc_hit = a; ecp_hit = b; stof_hit = c;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0; tbl = v;
    @(negedge clk);
    check(cfg_rdata == v, "R7", cfg_rdata, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] words[11];
    string wtag;
    logic [NS-1:0] a, b, c, e;
    words = '{8'hAA, 8'hCC, 8'hF0, 8'hFC, 8'hFA, 8'hEE, 8'hFE, 8'hC0, 8'hA0, 8'h88, 8'h80};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", {7'b0, out_valid}, 8'h00);
    check(cfg_rdata == 8'h00, "R1", cfg_rdata, 8'h00);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", {7'b0, in_ready}, 8'h01);
    check(cfg_rdata == 8'h00, "R1", cfg_rdata, 8'h00);

    // R11: unprogrammed table passes nothing
    for (int k = 0; k < 4; k++) send(6'h3F, 6'h3F >> k, 6'h2A, 6'h00, "R11");
    drain();

    // R8 R9 R10 with R2 index order, every index on every sector
    for (int w = 0; w < 11; w++) begin
      wtag = (w < 3) ? "R8" : (w < 7) ? "R9" : "R10";
      write_cfg(words[w]);
      for (int k = 0; k < 8; k++) begin
        for (int s = 0; s < NS; s++) begin
          int idx;
          idx = (k + s) % 8;
          a[s] = idx[2]; b[s] = idx[1]; c[s] = idx[0];
          e[s] = rule(w, a[s], b[s], c[s]);
        end
        send(a, b, c, e, wtag);
      end
      drain();
    end

    // R4: latency and drain
    write_cfg(8'hF0);
    @(posedge clk); #1;
    in_valid = 1'b1; ecc_hit = 6'h15; ecp_hit = 6'h00; stof_hit = 6'h3F;
    exp_q.push_back(6'h15); tag_q.push_back("R4");
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b1, "R4", {7'b0, out_valid}, 8'h01);
    @(negedge clk);
    check(out_valid == 1'b0, "R4", {7'b0, out_valid}, 8'h00);
    drain();

    // R6: write and accept on the same edge
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = 8'hAA;
    in_valid = 1'b1; ecc_hit = 6'h0F; ecp_hit = 6'h00; stof_hit = 6'h30;
    @(negedge clk);
    check(in_ready == 1'b1, "R6", {7'b0, in_ready}, 8'h01);
    exp_q.push_back(6'h0F); tag_q.push_back("R6");
    @(posedge clk); #1;
    cfg_we = 1'b0; in_valid = 1'b0; tbl = 8'hAA;
    send(6'h0F, 6'h00, 6'h30, 6'h30, "R6");
    drain();
    check(cfg_rdata == 8'hAA, "R7", cfg_rdata, 8'hAA);

    // R3 R5: random tables and hits under back-pressure
    bp_mode = 1'b1;
    for (int r = 0; r < 12; r++) begin
      write_cfg(8'($urandom));
      for (int k = 0; k < 10; k++) begin
        a = 6'($urandom); b = 6'($urandom); c = 6'($urandom);
        send(a, b, c, model(tbl, a, b, c), "R3");
      end
    end
    bp_mode = 1'b0;
    drain();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule